// File: doc/BRIEF.md
# Smart Card Contact Power Sequencer

This block steps the contact sets of several card slots (two by default) through power-up and power-down. It runs on an internal oscillator and counts in single oscillator cycles. One time unit T is a parameter, 64 cycles by default. For each slot it takes a level start request, a card-present input and an overcurrent flag. Two inputs are shared by all slots: a supply-supervisor-ok flag and an overheat flag. For each slot it produces enables for the card supply, the I/O line, the card clock and the reset driver, a clamp that holds the contacts low, and an in-session flag. One enable, for the single step-up converter, serves all slots.

A host sets the start request to open a session and clears it to close the session. If a fault ends a session, the block pulses a request to clear that slot's start bit. It also raises a one-cycle event telling the host why: a protection event or a presence event. The analog supply ramp and the answer-to-reset timing are handled elsewhere.

Top module: `card_pwr_seq`

## Requirements
- R1: Outside a session (after reset, or once power-down completes), a slot holds `clamp` high, holds `active` low and holds `vcc_en`, `io_en`, `clk_en` and `rst_en` low.
- R2: A slot starts power-up only when, at a clock edge, all of these hold: `start_req` is high, `present` is high, `sup_ok` is high, `overheat` is low and `fault_oc` is low. Otherwise it stays idle.
- R3: The first step, t1, is the clock edge that samples the accepted request. At t1 the slot raises `active`, drops `clamp` and requests the converter. `vcc_en` rises 3T/2 cycles after t1. `io_en` rises 7T/2 cycles after t1. `clk_en` and `rst_en` rise 4T cycles after t1.
- R4: `conv_en` is high whenever any slot is in session (`active` high). When a second slot starts while the converter is already on, `conv_en` stays high without a break.
- R5: When `start_req` falls during a session, the step t11 is the next edge. At t11 `rst_en` drops. `clk_en` drops T/2 cycles after t11, `io_en` drops T cycles after t11, and `vcc_en` drops 3T/2 cycles after t11.
- R6: 7T/2 cycles after t11 the slot raises `clamp` and drops `active`. `conv_en` falls at that same point only if no other slot is in session.
- R7: If `fault_oc` is high during a session, that slot alone runs the same power-down order. It pulses `start_clr` and `evt_prot` for one cycle at t11. Other slots keep running.
- R8: If `present` falls during a session, that slot alone powers down. It pulses `start_clr` and `evt_pres` for one cycle at t11, and `evt_prot` stays low.
- R9: If `overheat` is high, or `sup_ok` is low, every slot in session powers down on the same edge and pulses `start_clr`. Overheat also pulses `evt_prot`. A supervisor drop-out does not.
- R10: A start request that arrives during power-down has no effect until the slot is idle again: the power-down timing is unchanged. If the request is still high, power-up starts on the edge after the slot reaches idle.
- R11: If the request is withdrawn part way through power-up, only the enables already raised go through the power-down order. Enables not yet raised stay low. `active` stays high until the 7T/2 step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_req | input | NSLOT | Per-slot session request (level) |
| present | input | NSLOT | Per-slot card-present flag |
| fault_oc | input | NSLOT | Per-slot supply or reset overcurrent flag |
| sup_ok | input | 1 | Supply supervisor reports supply good |
| overheat | input | 1 | Die overheat flag |
| conv_en | output | 1 | Shared step-up converter enable |
| vcc_en | output | NSLOT | Card supply enable |
| io_en | output | NSLOT | Card I/O line enable |
| clk_en | output | NSLOT | Card clock enable |
| rst_en | output | NSLOT | Card reset driver enable (line held low) |
| clamp | output | NSLOT | Clamp all contacts low to ground |
| active | output | NSLOT | Slot is in session |
| start_clr | output | NSLOT | One-cycle pulse: clear this slot's start bit |
| evt_prot | output | NSLOT | One-cycle protection event pulse |
| evt_pres | output | NSLOT | One-cycle presence event pulse |

## Verification
Power-up and power-down are each sampled one cycle before and one cycle after every step. This separates a correct step offset from one that is off by one cycle in either direction.

Several stop causes are driven in turn: a host request, a per-slot overcurrent, card removal, overheat and supervisor drop-out. Each cause is checked against which slots shut down and which event flags pulse.

Two-slot runs show whether the converter stays on across overlapping sessions and whether it stops only with the last slot. A withdrawal part way through power-up and a start request raised during power-down show that the stored progress and the idle gate behave correctly.

// File: rtl/card_seq_pkg.sv
package card_seq_pkg;
   typedef enum logic [1:0] {
      SEQ_IDLE = 2'd0,
      SEQ_RAMP = 2'd1,
      SEQ_LIVE = 2'd2,
      SEQ_DOWN = 2'd3
   } seq_state_e;

   function automatic int step_width(input int t_cyc);
      return $clog2(4 * t_cyc + 1);
   endfunction
endpackage

// File: rtl/card_slot_seq.sv
module card_slot_seq
   import card_seq_pkg::*;
#(
   parameter int T_CYC = 64,
   localparam int CW = step_width(T_CYC)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_req,
   input  logic          present,
   input  logic          fault_oc,
   input  logic          sup_ok,
   input  logic          overheat,
   output seq_state_e    state,
   output logic [CW-1:0] cnt,
   output logic [CW-1:0] reach,
   output logic          start_clr,
   output logic          evt_prot,
   output logic          evt_pres
);
   localparam logic [CW-1:0] L_RAMP_END = CW'(4 * T_CYC - 1);
   localparam logic [CW-1:0] L_DOWN_END = CW'(7 * T_CYC / 2 - 1);
   localparam logic [CW-1:0] L_FULL     = CW'(4 * T_CYC);

   logic go_ok, local_trip, global_trip, in_sess, stop;

   assign go_ok       = start_req & present & sup_ok & ~overheat & ~fault_oc;
   assign local_trip  = fault_oc | ~present;
   assign global_trip = overheat | ~sup_ok;
   assign in_sess     = (state == SEQ_RAMP) || (state == SEQ_LIVE);
   assign stop        = in_sess & (~start_req | local_trip | global_trip);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= SEQ_IDLE;
         cnt       <= '0;
         reach     <= '0;
         start_clr <= 1'b0;
         evt_prot  <= 1'b0;
         evt_pres  <= 1'b0;
      end else begin
         start_clr <= 1'b0;
         evt_prot  <= 1'b0;
         evt_pres  <= 1'b0;
         if (stop) begin
            state     <= SEQ_DOWN;
            cnt       <= '0;
            reach     <= (state == SEQ_LIVE) ? L_FULL : cnt;
            start_clr <= local_trip | global_trip;
            evt_prot  <= fault_oc | overheat;
            evt_pres  <= ~present;
         end else begin
            unique case (state)
               SEQ_IDLE: if (go_ok) begin
                  state <= SEQ_RAMP;
                  cnt   <= '0;
               end
               SEQ_RAMP: if (cnt == L_RAMP_END) begin
                  state <= SEQ_LIVE;
                  cnt   <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
               SEQ_LIVE: cnt <= '0;
               SEQ_DOWN: if (cnt == L_DOWN_END) begin
                  state <= SEQ_IDLE;
                  cnt   <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
               default: state <= SEQ_IDLE;
            endcase
         end
      end
   end
endmodule

// File: rtl/card_contact_map.sv
module card_contact_map
   import card_seq_pkg::*;
#(
   parameter int T_CYC = 64,
   localparam int CW = step_width(T_CYC)
) (
   input  seq_state_e    state,
   input  logic [CW-1:0] cnt,
   input  logic [CW-1:0] reach,
   output logic          vcc_en,
   output logic          io_en,
   output logic          clk_en,
   output logic          rst_en,
   output logic          clamp,
   output logic          active
);
   localparam logic [CW-1:0] L_VCC_ON  = CW'(3 * T_CYC / 2);
   localparam logic [CW-1:0] L_IO_ON   = CW'(7 * T_CYC / 2);
   localparam logic [CW-1:0] L_FULL    = CW'(4 * T_CYC);
   localparam logic [CW-1:0] L_CLK_OFF = CW'(T_CYC / 2);
   localparam logic [CW-1:0] L_IO_OFF  = CW'(T_CYC);
   localparam logic [CW-1:0] L_VCC_OFF = CW'(3 * T_CYC / 2);

   logic ramp, live, down;

   assign ramp = (state == SEQ_RAMP);
   assign live = (state == SEQ_LIVE);
   assign down = (state == SEQ_DOWN);

   always_comb begin
      vcc_en = live | (ramp & (cnt >= L_VCC_ON))
                    | (down & (reach >= L_VCC_ON) & (cnt < L_VCC_OFF));
      io_en  = live | (ramp & (cnt >= L_IO_ON))
                    | (down & (reach >= L_IO_ON) & (cnt < L_IO_OFF));
      clk_en = live | (down & (reach >= L_FULL) & (cnt < L_CLK_OFF));
      rst_en = live;
      clamp  = (state == SEQ_IDLE);
      active = ~clamp;
   end
endmodule

// File: rtl/card_conv_share.sv
module card_conv_share #(
   parameter int NSLOT = 2
) (
   input  logic [NSLOT-1:0] in_session,
   output logic             conv_en
);
   generate
      if (NSLOT == 1) begin : g_single
         assign conv_en = in_session[0];
      end else begin : g_multi
         assign conv_en = |in_session;
      end
   endgenerate
endmodule

// File: rtl/card_pwr_seq.sv
module card_pwr_seq #(
   parameter int NSLOT = 2,
   parameter int T_CYC = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NSLOT-1:0] start_req,
   input  logic [NSLOT-1:0] present,
   input  logic [NSLOT-1:0] fault_oc,
   input  logic             sup_ok,
   input  logic             overheat,
   output logic             conv_en,
   output logic [NSLOT-1:0] vcc_en,
   output logic [NSLOT-1:0] io_en,
   output logic [NSLOT-1:0] clk_en,
   output logic [NSLOT-1:0] rst_en,
   output logic [NSLOT-1:0] clamp,
   output logic [NSLOT-1:0] active,
   output logic [NSLOT-1:0] start_clr,
   output logic [NSLOT-1:0] evt_prot,
   output logic [NSLOT-1:0] evt_pres
);
   localparam int CW = card_seq_pkg::step_width(T_CYC);

   generate
      if (NSLOT < 1) begin : g_bad_nslot
         $error("card_pwr_seq: NSLOT must be at least 1");
      end
      if ((T_CYC < 4) || (T_CYC % 2 != 0)) begin : g_bad_tcyc
         $error("card_pwr_seq: T_CYC must be even and at least 4");
      end
   endgenerate

   generate
      for (genvar s = 0; s < NSLOT; s++) begin : g_slot
         card_seq_pkg::seq_state_e st;
         logic [CW-1:0] cnt, reach;

         card_slot_seq #(.T_CYC(T_CYC)) u_seq (
            .clk       (clk),
            .rst_n     (rst_n),
            .start_req (start_req[s]),
            .present   (present[s]),
            .fault_oc  (fault_oc[s]),
            .sup_ok    (sup_ok),
            .overheat  (overheat),
            .state     (st),
            .cnt       (cnt),
            .reach     (reach),
            .start_clr (start_clr[s]),
            .evt_prot  (evt_prot[s]),
            .evt_pres  (evt_pres[s])
         );

         card_contact_map #(.T_CYC(T_CYC)) u_map (
            .state  (st),
            .cnt    (cnt),
            .reach  (reach),
            .vcc_en (vcc_en[s]),
            .io_en  (io_en[s]),
            .clk_en (clk_en[s]),
            .rst_en (rst_en[s]),
            .clamp  (clamp[s]),
            .active (active[s])
         );
      end
   endgenerate

   card_conv_share #(.NSLOT(NSLOT)) u_conv (
      .in_session (active),
      .conv_en    (conv_en)
   );
endmodule

// File: rtl/card_pwr_seq_chk.sv
module card_pwr_seq_chk #(
   parameter int NSLOT = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic [NSLOT-1:0] present,
   input logic             sup_ok,
   input logic             conv_en,
   input logic [NSLOT-1:0] vcc_en,
   input logic [NSLOT-1:0] io_en,
   input logic [NSLOT-1:0] clk_en,
   input logic [NSLOT-1:0] rst_en,
   input logic [NSLOT-1:0] clamp,
   input logic [NSLOT-1:0] active,
   input logic [NSLOT-1:0] start_clr
);
   a_r6_conv_off_only_when_all_idle: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(conv_en) |-> (active == '0));

   for (genvar s = 0; s < NSLOT; s++) begin : g_chk
      a_r1_clamped_contacts_quiet: assert property (@(posedge clk) disable iff (!rst_n)
         clamp[s] |-> !(vcc_en[s] | io_en[s] | clk_en[s] | rst_en[s]));
      a_r2_start_gated: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(active[s]) |-> $past(present[s] & sup_ok));
      a_r3_io_needs_supply: assert property (@(posedge clk) disable iff (!rst_n)
         io_en[s] |-> vcc_en[s]);
      a_r5_clock_needs_io: assert property (@(posedge clk) disable iff (!rst_n)
         clk_en[s] |-> io_en[s]);
      a_r5_reset_needs_clock: assert property (@(posedge clk) disable iff (!rst_n)
         rst_en[s] |-> clk_en[s]);
      a_r4_supply_needs_conv: assert property (@(posedge clk) disable iff (!rst_n)
         vcc_en[s] |-> conv_en);
      a_r7_clear_only_from_session: assert property (@(posedge clk) disable iff (!rst_n)
         start_clr[s] |-> $past(active[s]) && !rst_en[s]);
   end
endmodule

bind card_pwr_seq card_pwr_seq_chk #(.NSLOT(NSLOT)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .present   (present),
   .sup_ok    (sup_ok),
   .conv_en   (conv_en),
   .vcc_en    (vcc_en),
   .io_en     (io_en),
   .clk_en    (clk_en),
   .rst_en    (rst_en),
   .clamp     (clamp),
   .active    (active),
   .start_clr (start_clr)
);

// File: tb/sim_card_pwr_seq.sv
module sim_card_pwr_seq;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] start_req = '0, present = 2'b11, fault_oc = '0;
   logic       sup_ok = 1'b1, overheat = 1'b0;
   logic       conv_en;
   logic [1:0] vcc_en, io_en, clk_en, rst_en, clamp, active, start_clr, evt_prot, evt_pres;
   int n_chk = 0, n_fail = 0;

   always #5 clk = ~clk;

   card_pwr_seq #(.NSLOT(2), .T_CYC(64)) u0 (
      .clk, .rst_n, .start_req, .present, .fault_oc, .sup_ok, .overheat,
      .conv_en, .vcc_en, .io_en, .clk_en, .rst_en, .clamp, .active,
      .start_clr, .evt_prot, .evt_pres
   );

   task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_reset();
      rst_n = 1'b0; start_req = '0; present = 2'b11; fault_oc = '0;
      sup_ok = 1'b1; overheat = 1'b0;
      tick(3);
      rst_n = 1'b1;
      tick(1);
   endtask

   task automatic bring_up(logic [1:0] m);
      start_req = start_req | m;
      tick(258);
   endtask

   task automatic t_reset();
      do_reset();
      check("R1", "clamp", 32'(clamp), 32'h3);
      check("R1", "enables", 32'({vcc_en, io_en, clk_en, rst_en}), 32'h0);
      check("R1", "active/conv", 32'({active, conv_en}), 32'h0);
   endtask

   task automatic t_gate();
      do_reset();
      present = 2'b10; start_req = 2'b01; tick(5);
      check("R2", "no card", 32'(active), 32'h0);
      present = 2'b11; sup_ok = 1'b0; tick(5);
      check("R2", "supervisor", 32'(active), 32'h0);
      sup_ok = 1'b1; fault_oc = 2'b01; tick(5);
      check("R2", "overcurrent", 32'({active, conv_en}), 32'h0);
      fault_oc = '0; tick(1);
      check("R2", "all ok", 32'(active), 32'h1);
   endtask

   task automatic t_activate();
      do_reset();
      start_req = 2'b01;
      tick(1);
      check("R3", "t1 active", 32'({active[0], clamp[0], conv_en, vcc_en[0]}), 32'b1010);
      tick(95);  check("R3", "vcc before", 32'(vcc_en[0]), 0);
      tick(1);   check("R3", "vcc at 3T/2", 32'({vcc_en[0], io_en[0]}), 32'b10);
      tick(127); check("R3", "io before", 32'(io_en[0]), 0);
      tick(1);   check("R3", "io at 7T/2", 32'({io_en[0], clk_en[0]}), 32'b10);
      tick(31);  check("R3", "clk before", 32'({clk_en[0], rst_en[0]}), 0);
      tick(1);   check("R3", "clk/rst at 4T", 32'({clk_en[0], rst_en[0]}), 32'b11);
   endtask

   task automatic t_deactivate();
      do_reset();
      bring_up(2'b01);
      start_req = 2'b00;
      tick(1);   check("R5", "t11 reset low", 32'({rst_en[0], clk_en[0], active[0]}), 32'b011);
      tick(31);  check("R5", "clk before T/2", 32'(clk_en[0]), 1);
      tick(1);   check("R5", "clk at T/2", 32'({clk_en[0], io_en[0]}), 32'b01);
      tick(31);  check("R5", "io before T", 32'(io_en[0]), 1);
      tick(1);   check("R5", "io at T", 32'({io_en[0], vcc_en[0]}), 32'b01);
      tick(31);  check("R5", "vcc before 3T/2", 32'(vcc_en[0]), 1);
      tick(1);   check("R5", "vcc at 3T/2", 32'({vcc_en[0], active[0], conv_en}), 32'b011);
      tick(127); check("R6", "before 7T/2", 32'({active[0], clamp[0], conv_en}), 32'b101);
      tick(1);   check("R6", "at 7T/2", 32'({active[0], clamp[0], conv_en}), 32'b010);
   endtask

   task automatic t_share();
      do_reset();
      bring_up(2'b01);
      start_req = 2'b11;
      tick(1);   check("R4", "second start keeps conv", 32'({conv_en, active[1]}), 32'b11);
      tick(257);
      start_req = 2'b10;
      tick(225); check("R6", "slot0 done, conv kept", 32'({clamp[0], conv_en, vcc_en[1]}), 32'b111);
      start_req = 2'b00;
      tick(224); check("R4", "conv before last end", 32'(conv_en), 1);
      tick(1);   check("R6", "conv off with last", 32'(conv_en), 0);
   endtask

   task automatic t_oc();
      do_reset();
      bring_up(2'b11);
      fault_oc = 2'b01;
      tick(1);
      check("R7", "start_clr", 32'(start_clr), 32'h1);
      check("R7", "evt_prot/pres", 32'({evt_prot, evt_pres}), 32'b0100);
      check("R7", "other slot kept", 32'(rst_en), 32'h2);
      fault_oc = '0; start_req = 2'b10;
      tick(1);   check("R7", "pulse one cycle", 32'({start_clr, evt_prot}), 0);
      tick(223); check("R7", "slot0 idle, slot1 on", 32'({clamp[0], active[1]}), 32'b11);
   endtask

   task automatic t_removal();
      do_reset();
      bring_up(2'b10);
      present = 2'b01;
      tick(1);
      check("R8", "start_clr", 32'(start_clr), 32'h2);
      check("R8", "evt_pres/prot", 32'({evt_pres, evt_prot}), 32'b1000);
      start_req = 2'b00;
      tick(224); check("R8", "slot1 clamped", 32'(clamp[1]), 1);
      present = 2'b11;
   endtask

   task automatic t_global();
      do_reset();
      bring_up(2'b11);
      overheat = 1'b1;
      tick(1);
      check("R9", "overheat clears both", 32'({start_clr, evt_prot}), 32'b1111);
      check("R9", "both reset low", 32'(rst_en), 0);
      overheat = 1'b0; start_req = 2'b00;
      tick(224); check("R9", "both idle", 32'({clamp, conv_en}), 32'b110);
      bring_up(2'b11);
      sup_ok = 1'b0;
      tick(1);
      check("R9", "dropout clears both", 32'({start_clr, evt_prot}), 32'b1100);
      sup_ok = 1'b1; start_req = 2'b00;
      tick(224); check("R9", "dropout idle", 32'(clamp), 32'h3);
   endtask

   task automatic t_restart();
      do_reset();
      bring_up(2'b01);
      start_req = 2'b00;
      tick(10);
      start_req = 2'b01;
      tick(90);  check("R10", "down continues", 32'({vcc_en[0], rst_en[0], active[0]}), 32'b001);
      tick(124); check("R10", "still down", 32'({clamp[0], vcc_en[0]}), 32'b00);
      tick(1);   check("R10", "reaches idle", 32'({clamp[0], active[0]}), 32'b10);
      tick(1);   check("R10", "restarts", 32'({clamp[0], active[0]}), 32'b01);
   endtask

   task automatic t_abort();
      do_reset();
      start_req = 2'b01;
      tick(51);
      start_req = 2'b00;
      tick(1);   check("R11", "early abort", 32'({vcc_en[0], io_en[0], active[0]}), 32'b001);
      tick(150); check("R11", "vcc never up", 32'({vcc_en[0], active[0]}), 32'b01);
      tick(74);  check("R11", "idle after 7T/2", 32'({clamp[0], active[0]}), 32'b10);
      start_req = 2'b01;
      tick(151); check("R11", "vcc up mid ramp", 32'(vcc_en[0]), 1);
      start_req = 2'b00;
      tick(1);   check("R11", "io stays low", 32'({vcc_en[0], io_en[0], clk_en[0]}), 32'b100);
      tick(95);  check("R11", "vcc before 3T/2", 32'(vcc_en[0]), 1);
      tick(1);   check("R11", "vcc off", 32'({vcc_en[0], active[0]}), 32'b01);
      tick(128); check("R11", "idle", 32'(clamp[0]), 1);
   endtask

   initial begin
      t_reset();
      t_gate();
      t_activate();
      t_deactivate();
      t_share();
      t_oc();
      t_removal();
      t_global();
      t_restart();
      t_abort();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #2000000;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule